// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a configuration register file from a three-wire serial EEPROM as soon as reset is released. It acts as the bus master toward the EEPROM and reads 16-bit words one at a time. It derives the serial clock from the system clock through a programmable divider. Each read is a complete transaction, framed by chip select.

The stored image is a list of records. Each record takes two consecutive words: a control word, then a data word. The control word holds four fields:
- a target register address in its low byte;
- six reserved bits that must be zero;
- an end-of-list flag;
- a parity bit chosen so that the 32 bits of the record hold an odd number of ones.

Each record is evaluated when its data word arrives. A sound record becomes a single write on the register-write port. A record with bad parity is dropped and sets a sticky error bit. A record with nonzero reserved bits is dropped silently.

Loading stops after the record that carries the end-of-list flag. If no record carries the flag, loading stops once the last word of the EEPROM has been read. The done output then rises and stays high until the next reset.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While reset is held, chip select, serial clock, data out, the write strobe, done and the parity-error bit are all 0.
- R2: Every word read begins with chip select rising, followed by nine bits on data out, each stable while the serial clock is high and captured on its rising edge: 1, 1, 0, then the 6-bit word address, most significant bit first.
- R3: After the nine command bits, the rising edge of the tenth serial clock reads a dummy bit that is ignored. The next sixteen rising edges read the data word, most significant bit first.
- R4: The serial clock is low whenever chip select is low. Between two word reads, chip select stays low for at least one serial clock period, which is 2*HALF_DIV system clocks.
- R5: Words are read at consecutive addresses starting from 0. The control word of each record sits at an even address and its data word at the next odd address.
- R6: A record with odd overall parity and zero reserved bits (control bits 13:8) produces one write. The write address is control bits 7:0 and the write data is the data word.
- R7: A record whose 32 bits hold an even number of ones produces no write. It sets the parity-error bit, which then stays 1 until reset.
- R8: A record whose reserved bits are nonzero but whose parity is correct produces no write and leaves the parity-error bit unchanged.
- R9: A record with control bit 14 set is the last one processed, whatever the outcome of its checks. After it, done rises and stays 1, and chip select remains low.
- R10: When no record carries the end-of-list flag, loading ends after the record stored at words 62 and 63, which is 32 records in total.
- R11: The write strobe is high for exactly one cycle per accepted record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; loading starts on release |
| mw_cs_o | output | 1 | EEPROM chip select, active high |
| mw_sk_o | output | 1 | EEPROM serial clock |
| mw_do_o | output | 1 | Command and address bits toward the EEPROM |
| mw_di_i | input | 1 | Read data from the EEPROM |
| wr_en_o | output | 1 | Register-file write strobe |
| wr_addr_o | output | 8 | Register-file target address |
| wr_data_o | output | 16 | Register-file write data |
| done_o | output | 1 | Loading finished (held) |
| perr_o | output | 1 | Sticky record parity-error status |

## Verification
A bit counter that is off by one shifts every captured word by one bit. This corrupts the next write, or turns a good record into a parity failure, by the end of the first record, roughly 450 system clocks after reset. A wrong word address, or a record sequencer that skips a step, shows on data out within the nine command bits of the affected read. A stop decision that is wrong shows as an extra chip-select pulse, or a missing one, after the record that should be last. Mistakes in the accept, drop or error decisions appear on the write port or the error bit in the cycle after the data word arrives.

// File: rtl/eeld_pkg.sv
package eeld_pkg;

   localparam int WORD_W   = 16;
   localparam int REG_AW   = 8;
   localparam int PAR_POS  = 15;
   localparam int LAST_POS = 14;
   localparam int RSV_HI   = 13;
   localparam int RSV_LO   = 8;

   typedef logic [WORD_W-1:0] word_t;

   typedef enum logic [1:0] {
      RD_IDLE,
      RD_RUN,
      RD_GAP
   } rd_state_t;

   typedef enum logic [2:0] {
      LD_REQ_A,
      LD_WAIT_A,
      LD_REQ_D,
      LD_WAIT_D,
      LD_EVAL,
      LD_DONE
   } ld_state_t;

   typedef struct packed {
      logic              par_bad;
      logic              rsv_bad;
      logic              last;
      logic [REG_AW-1:0] tgt;
   } rec_info_t;

endpackage

// File: rtl/eeld_sync.sv
module eeld_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 1) begin : g_bad
         $error("eeld_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic q_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_q <= 1'b0;
            else        q_q <= d_i;
         end
         assign q_o = q_q;
      end else begin : g_chain
         logic [STAGES-1:0] ch_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ch_q <= '0;
            else        ch_q <= {ch_q[STAGES-2:0], d_i};
         end
         assign q_o = ch_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/eeld_rec_chk.sv
module eeld_rec_chk
   import eeld_pkg::*;
#(
   parameter bit PAR_ODD = 1'b1
) (
   input  word_t     ctl_i,
   input  word_t     dat_i,
   output rec_info_t info_o
);

   logic x_all;

   assign x_all = ^{ctl_i, dat_i};

   generate
      if (PAR_ODD) begin : g_odd
         assign info_o.par_bad = ~x_all;
      end else begin : g_even
         assign info_o.par_bad = x_all;
      end
   endgenerate

   assign info_o.rsv_bad = |ctl_i[RSV_HI:RSV_LO];
   assign info_o.last    = ctl_i[LAST_POS];
   assign info_o.tgt     = ctl_i[REG_AW-1:0];

endmodule

// File: rtl/eeld_mw_reader.sv
module eeld_mw_reader
   import eeld_pkg::*;
#(
   parameter int HALF_DIV    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              rdy_o,
   output logic              vld_o,
   output word_t             word_o,
   output logic              cs_o,
   output logic              sk_o,
   output logic              do_o,
   input  logic              di_i
);

   localparam int CMD_W   = 3 + ADDR_W;
   localparam int FIRST_K = CMD_W + 1;
   localparam int LAST_K  = CMD_W + WORD_W;
   localparam int K_W     = $clog2(LAST_K + 1);
   localparam int DIV_W   = $clog2(HALF_DIV + 1);
   localparam int GAP     = 2 * HALF_DIV;
   localparam int GAP_W   = $clog2(GAP + 1);

   rd_state_t          st_q;
   logic [DIV_W-1:0]   div_q;
   logic [K_W-1:0]     k_q;
   logic [GAP_W-1:0]   gap_q;
   logic [CMD_W-1:0]   cmd_q;
   word_t              sh_q;
   logic               cs_q, sk_q, vld_q;
   logic               di_s;
   logic               tick;

   eeld_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (di_i),
      .q_o   (di_s)
   );

   assign tick = (div_q == DIV_W'(HALF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= RD_IDLE;
         div_q <= '0;
         k_q   <= '0;
         gap_q <= '0;
         cmd_q <= '0;
         sh_q  <= '0;
         cs_q  <= 1'b0;
         sk_q  <= 1'b0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         case (st_q)
            RD_IDLE: begin
               if (start_i) begin
                  st_q  <= RD_RUN;
                  cs_q  <= 1'b1;
                  sk_q  <= 1'b0;
                  div_q <= '0;
                  k_q   <= '0;
                  cmd_q <= {3'b110, addr_i};
               end
            end
            RD_RUN: begin
               if (tick) begin
                  div_q <= '0;
                  if (!sk_q) begin
                     sk_q <= 1'b1;
                     if (k_q >= K_W'(FIRST_K))
                        sh_q <= {sh_q[WORD_W-2:0], di_s};
                  end else begin
                     sk_q  <= 1'b0;
                     cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
                     if (k_q == K_W'(LAST_K)) begin
                        cs_q  <= 1'b0;
                        st_q  <= RD_GAP;
                        gap_q <= '0;
                     end else begin
                        k_q <= k_q + 1'b1;
                     end
                  end
               end else begin
                  div_q <= div_q + 1'b1;
               end
            end
            RD_GAP: begin
               if (gap_q == GAP_W'(GAP - 1)) begin
                  vld_q <= 1'b1;
                  st_q  <= RD_IDLE;
               end else begin
                  gap_q <= gap_q + 1'b1;
               end
            end
            default: st_q <= RD_IDLE;
         endcase
      end
   end

   assign rdy_o  = (st_q == RD_IDLE);
   assign vld_o  = vld_q;
   assign word_o = sh_q;
   assign cs_o   = cs_q;
   assign sk_o   = sk_q;
   assign do_o   = cmd_q[CMD_W-1];

   // chip-select low-time tracker for the gap property
   localparam int LOW_W = $clog2(GAP + 1);
   logic [LOW_W-1:0] low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           low_q <= LOW_W'(GAP);
      else if (cs_q)                        low_q <= '0;
      else if (low_q != LOW_W'(GAP))        low_q <= low_q + 1'b1;
   end

   p_sk_low_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_o |-> !sk_o);

   p_cs_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_o) |-> (low_q >= LOW_W'(GAP)));

   p_do_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sk_o && $past(sk_o)) |-> $stable(do_o));

endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader
   import eeld_pkg::*;
#(
   parameter int HALF_DIV    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 6,
   parameter bit PAR_ODD     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mw_cs_o,
   output logic              mw_sk_o,
   output logic              mw_do_o,
   input  logic              mw_di_i,
   output logic              wr_en_o,
   output logic [REG_AW-1:0] wr_addr_o,
   output logic [WORD_W-1:0] wr_data_o,
   output logic              done_o,
   output logic              perr_o
);

   localparam int PI_W = ADDR_W - 1;

   generate
      if (SYNC_STAGES < 1) begin : g_chk_sync
         $error("cfg_eeprom_loader: SYNC_STAGES must be at least 1");
      end
      if (HALF_DIV < SYNC_STAGES + 1) begin : g_chk_div
         $error("cfg_eeprom_loader: HALF_DIV too small for the input synchronizer");
      end
      if (ADDR_W < 2) begin : g_chk_aw
         $error("cfg_eeprom_loader: ADDR_W must be at least 2");
      end
   endgenerate

   ld_state_t          st_q;
   logic [PI_W-1:0]    pi_q;
   word_t              ctl_q, dat_q;
   logic               wr_en_q, perr_q, done_q;
   logic [REG_AW-1:0]  wr_addr_q;
   word_t              wr_data_q;

   logic               rd_rdy, rd_vld, rd_start;
   word_t              rd_word;
   logic [ADDR_W-1:0]  rd_addr;
   rec_info_t          info;

   assign rd_start = rd_rdy && ((st_q == LD_REQ_A) || (st_q == LD_REQ_D));
   assign rd_addr  = {pi_q, (st_q == LD_REQ_D)};

   eeld_mw_reader #(
      .HALF_DIV    (HALF_DIV),
      .SYNC_STAGES (SYNC_STAGES),
      .ADDR_W      (ADDR_W)
   ) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (rd_start),
      .addr_i  (rd_addr),
      .rdy_o   (rd_rdy),
      .vld_o   (rd_vld),
      .word_o  (rd_word),
      .cs_o    (mw_cs_o),
      .sk_o    (mw_sk_o),
      .do_o    (mw_do_o),
      .di_i    (mw_di_i)
   );

   eeld_rec_chk #(.PAR_ODD(PAR_ODD)) u_chk (
      .ctl_i  (ctl_q),
      .dat_i  (dat_q),
      .info_o (info)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= LD_REQ_A;
         pi_q      <= '0;
         ctl_q     <= '0;
         dat_q     <= '0;
         wr_en_q   <= 1'b0;
         wr_addr_q <= '0;
         wr_data_q <= '0;
         perr_q    <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         wr_en_q <= 1'b0;
         case (st_q)
            LD_REQ_A:  if (rd_rdy) st_q <= LD_WAIT_A;
            LD_WAIT_A: if (rd_vld) begin
                          ctl_q <= rd_word;
                          st_q  <= LD_REQ_D;
                       end
            LD_REQ_D:  if (rd_rdy) st_q <= LD_WAIT_D;
            LD_WAIT_D: if (rd_vld) begin
                          dat_q <= rd_word;
                          st_q  <= LD_EVAL;
                       end
            LD_EVAL: begin
               if (!info.par_bad && !info.rsv_bad) begin
                  wr_en_q   <= 1'b1;
                  wr_addr_q <= info.tgt;
                  wr_data_q <= dat_q;
               end
               if (info.par_bad) perr_q <= 1'b1;
               if (info.last || (&pi_q)) begin
                  st_q   <= LD_DONE;
                  done_q <= 1'b1;
               end else begin
                  pi_q <= pi_q + 1'b1;
                  st_q <= LD_REQ_A;
               end
            end
            LD_DONE:  st_q <= LD_DONE;
            default:  st_q <= LD_DONE;
         endcase
      end
   end

   assign wr_en_o   = wr_en_q;
   assign wr_addr_o = wr_addr_q;
   assign wr_data_o = wr_data_q;
   assign perr_o    = perr_q;
   assign done_o    = done_q;

   p_wr_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_en_o);

   p_perr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      perr_o |=> perr_o);

   p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> done_o);

   p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !mw_cs_o);

   p_wr_after_eval_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> $past(st_q == LD_EVAL));

endmodule

// File: tb/tb_cfg_eeprom_loader.sv
module tb_cfg_eeprom_loader;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        di = 1'b0;
   logic        cs, sk, dout, wr_en, done, perr;
   logic [7:0]  wr_addr;
   logic [15:0] wr_data;

   always #5 clk = ~clk;

   cfg_eeprom_loader dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mw_cs_o   (cs),
      .mw_sk_o   (sk),
      .mw_do_o   (dout),
      .mw_di_i   (di),
      .wr_en_o   (wr_en),
      .wr_addr_o (wr_addr),
      .wr_data_o (wr_data),
      .done_o    (done),
      .perr_o    (perr)
   );

   int          n_chk = 0;
   int          n_fail = 0;
   logic [15:0] mem [64];
   logic [23:0] exp_q [$];
   bit          exp_perr;
   int          exp_words;
   int          words_seen;
   bit          done_seen, perr_seen, cs_seen, prev_wr;
   int          low_run;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   function automatic logic [15:0] mk_ctl(input bit last, input logic [5:0] rsv,
                                          input logic [7:0] tgt, input logic [15:0] d,
                                          input bit good);
      logic x;
      x = ^{last, rsv, tgt, d};
      return {(good ? ~x : x), last, rsv, tgt};
   endfunction

   // behavioural reference: expected writes, error bit and word count
   task automatic build_expect();
      exp_q.delete();
      exp_perr  = 1'b0;
      exp_words = 0;
      for (int i = 0; i < 32; i++) begin
         logic [15:0] a, d;
         a = mem[2*i];
         d = mem[2*i+1];
         exp_words += 2;
         if ((^{a, d}) == 1'b1 && a[13:8] == 6'd0) exp_q.push_back({a[7:0], d});
         if ((^{a, d}) == 1'b0) exp_perr = 1'b1;
         if (a[14]) break;
      end
   endtask

   // serial EEPROM model
   int          ee_cnt = 0;
   logic [7:0]  ee_cmd = '0;
   logic [15:0] ee_word = '0;
   logic        prev_sk = 1'b0;

   always @(posedge clk) begin
      if (!cs) begin
         ee_cnt = 0;
      end else if (sk && !prev_sk) begin
         ee_cnt = ee_cnt + 1;
         if (ee_cnt == 9) begin
            // R2 / R5: command 110 followed by the expected address
            chk(ee_cmd[7:5] == 3'b110, "R2", "read opcode", {29'd0, ee_cmd[7:5]}, 32'd6);
            chk({ee_cmd[4:0], dout} == 6'(words_seen), "R5", "word address",
                {26'd0, ee_cmd[4:0], dout}, 32'(words_seen));
            ee_word = mem[{ee_cmd[4:0], dout}];
            words_seen++;
            di <= 1'b0;
         end else if (ee_cnt < 9) begin
            ee_cmd = {ee_cmd[6:0], dout};
         end else if (ee_cnt <= 25) begin
            di <= ee_word[25-ee_cnt];
         end
      end
      prev_sk = sk;
   end

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (rst_n) begin
         if (!cs) chk(!sk, "R4", "serial clock while deselected", {31'd0, sk}, 32'd0);
         if (wr_en) begin
            chk(!prev_wr, "R11", "strobe width", 32'd2, 32'd1);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8", "unexpected write", {8'd0, wr_addr, wr_data}, 32'd0);
            end else begin
               logic [23:0] e;
               e = exp_q.pop_front();
               chk({wr_addr, wr_data} == e, "R6", "write addr/data",
                   {8'd0, wr_addr, wr_data}, {8'd0, e});
            end
         end
         if (done_seen) chk(done, "R9", "done held", {31'd0, done}, 32'd1);
         if (done)      chk(!cs, "R9", "select after done", {31'd0, cs}, 32'd0);
         if (perr_seen) chk(perr, "R7", "error bit sticky", {31'd0, perr}, 32'd1);
         if (cs && low_run >= 0) begin
            if (cs_seen && low_run > 0)
               chk(low_run >= 8, "R4", "deselect gap", 32'(low_run), 32'd8);
            low_run = 0;
            cs_seen = 1'b1;
         end else if (!cs) begin
            low_run++;
         end
         prev_wr   = wr_en;
         done_seen = done_seen | done;
         perr_seen = perr_seen | perr;
      end
   end

   task automatic run(input string name);
      rst_n = 1'b0;
      build_expect();
      words_seen = 0;
      done_seen = 1'b0;
      perr_seen = 1'b0;
      cs_seen = 1'b0;
      prev_wr = 1'b0;
      low_run = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk({cs, sk, dout, wr_en, done, perr} == 6'd0, "R1", {name, " reset state"},
          {26'd0, cs, sk, dout, wr_en, done, perr}, 32'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 30000 && !done; i++) @(negedge clk);
      repeat (300) @(negedge clk);
      chk(done, "R9", {name, " done"}, {31'd0, done}, 32'd1);
      chk(exp_q.size() == 0, "R6", {name, " missing writes"}, 32'(exp_q.size()), 32'd0);
      chk(perr == exp_perr, "R7", {name, " error bit"}, {31'd0, perr}, {31'd0, exp_perr});
      chk(words_seen == exp_words, "R10", {name, " words read"}, 32'(words_seen), 32'(exp_words));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // image A: good, reserved bits set (R8), good with end flag (R9)
      for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
      mem[0] = mk_ctl(1'b0, 6'd0,  8'h12, 16'hBEEF, 1'b1); mem[1] = 16'hBEEF;
      mem[2] = mk_ctl(1'b0, 6'd5,  8'h34, 16'h1234, 1'b1); mem[3] = 16'h1234;
      mem[4] = mk_ctl(1'b1, 6'd0,  8'hFF, 16'h0001, 1'b1); mem[5] = 16'h0001;
      run("A");
      chk(perr == 1'b0, "R8", "reserved record leaves error bit", {31'd0, perr}, 32'd0);

      // image B: parity faults (R7), end flag on a bad record (R9)
      for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
      mem[0] = mk_ctl(1'b0, 6'd0, 8'h00, 16'hFFFF, 1'b1); mem[1] = 16'hFFFF;
      mem[2] = mk_ctl(1'b0, 6'd0, 8'h55, 16'h00A5, 1'b0); mem[3] = 16'h00A5;
      mem[4] = mk_ctl(1'b0, 6'd0, 8'hAA, 16'h8001, 1'b1); mem[5] = 16'h8001;
      mem[6] = mk_ctl(1'b1, 6'd0, 8'h77, 16'h7777, 1'b0); mem[7] = 16'h7777;
      mem[8] = mk_ctl(1'b0, 6'd0, 8'h99, 16'h9999, 1'b1); mem[9] = 16'h9999;
      run("B");

      // image C: 32 sound records, no end flag (R10, R3 bit order)
      for (int i = 0; i < 32; i++) begin
         logic [15:0] d;
         d = 16'h1000 + 16'(i) * 16'h0111;
         mem[2*i]   = mk_ctl(1'b0, 6'd0, 8'(i * 5), d, 1'b1);
         mem[2*i+1] = d;
      end
      run("C");
      chk(words_seen == 64, "R10", "whole device read", 32'(words_seen), 32'd64);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule